// File: doc/BRIEF.md
# Multi-Policy Float-to-Integer Converter

This block turns an IEEE754 binary64 or binary32 operand into a 32-bit or 64-bit integer, signed or unsigned, ready to be written to an integer register. A 3-bit mode field picks two things at once. Its low bit chooses between the dynamic rounding mode input and forced truncation. Its upper two bits choose what happens to NaN and to values outside the destination range. Two policies clamp to the destination limits and differ only in the value a NaN produces. The third wraps the rounded value modulo 2^N.

The datapath has two register stages. Stage one unpacks the operand, aligns the mantissa on a fixed-point grid and rounds it. Stage two applies the range policy and extends narrow results to 64 bits. Each request appears at the output exactly two cycles after it is presented. Mode codes that select no policy raise an illegal flag and return zero.

Top module: `fp2int_cvt`

## Requirements
- R1: Mode values 3'b110 and 3'b111 drive `illegal` high with `result` equal to zero; every other mode drives `illegal` low.
- R2: With mode 3'b000 or 3'b001 (clamp, NaN to minimum), a NaN operand returns the destination minimum: 0 when unsigned, -2^(N-1) when signed.
- R3: With mode 3'b010 or 3'b011 (clamp, NaN to zero), a NaN operand returns 0.
- R4: Under both clamping policies, a rounded value above the destination maximum returns the maximum and one below the minimum returns the minimum; infinities and magnitudes of 2^64 or more clamp by their sign.
- R5: When mode bit 0 is 0, in-range values round per `rnd_mode`: 2'b00 to nearest with ties to even, 2'b01 toward zero, 2'b10 toward +infinity, 2'b11 toward -infinity.
- R6: When mode bit 0 is 1, the value is truncated toward zero whatever `rnd_mode` holds.
- R7: With mode 3'b100 or 3'b101 (wrap), NaN and both infinities return 0.
- R8: Under the wrap policy, the rounded value is reduced modulo 2^N to a non-negative residue and then reinterpreted in the destination type; magnitudes of 2^64 or more keep their low bits, and unbiased exponents of 52+N or more give 0.
- R9: `src_dbl` = 1 reads all 64 operand bits as binary64; `src_dbl` = 0 reads only `operand[31:0]` as binary32, and the upper half has no effect. Binary32 subnormals are converted by value.
- R10: A 32-bit result is sign-extended to 64 bits when `dst_signed` = 1 and zero-extended when it is 0.
- R11: `out_valid` is high exactly two cycles after `in_valid`, and `result` and `illegal` belong to that request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Request present this cycle |
| operand | input | 64 | Floating-point bits (binary32 uses bits 31:0) |
| src_dbl | input | 1 | 1 = binary64 source, 0 = binary32 source |
| dst_wide | input | 1 | 1 = 64-bit destination, 0 = 32-bit destination |
| dst_signed | input | 1 | 1 = signed destination, 0 = unsigned |
| mode | input | 3 | Rounding source (bit 0) and range policy (bits 2:1) |
| rnd_mode | input | 2 | Dynamic rounding mode |
| out_valid | output | 1 | Result present this cycle |
| result | output | 64 | Converted integer, extended to 64 bits |
| illegal | output | 1 | Mode code selects no policy |

## Verification
The bench builds the block with the package defaults: a 64-bit register width and a 32-bit narrow destination. With these widths both destination sizes can be exercised in the same run. The 32-bit limits (2^31 and 2^32) and the 64-bit limits (2^63 and 2^64) can both be reached with exactly representable binary64 operands. The default widths also put the wrap policy's two extra cases in range: a magnitude just above 2^64 that keeps its low bits, and an exponent of 84 that folds to zero in a 32-bit destination.

// File: rtl/fp2int_pkg.sv
package fp2int_pkg;
  localparam int XLEN     = 64;
  localparam int NLEN     = 32;
  localparam int DP_EW    = 11;
  localparam int DP_FW    = 52;
  localparam int SP_EW    = 8;
  localparam int SP_FW    = 23;
  localparam int MANT_W   = DP_FW + 1;
  localparam int EXP_W    = 13;
  localparam int DP_BIAS  = (1 << (DP_EW - 1)) - 1;
  localparam int SP_BIAS  = (1 << (SP_EW - 1)) - 1;
  localparam int FRAC_LSB = 66;
  localparam int GRID_W   = FRAC_LSB + XLEN;
  localparam int LOW_CUT  = FRAC_LSB - DP_FW;

  typedef enum logic [1:0] {
    POL_CLAMP_MIN  = 2'b00,
    POL_CLAMP_ZERO = 2'b01,
    POL_WRAP       = 2'b10,
    POL_NONE       = 2'b11
  } pol_e;

  typedef struct packed {
    logic          sign;
    logic          nan;
    logic          inf;
    logic          big;
    logic [XLEN:0] mag;
    logic [XLEN-1:0] modv;
    logic          wide;
    logic          sgn;
    pol_e          pol;
  } s1_t;
endpackage

// File: rtl/fp2int_unpack.sv
module fp2int_unpack
  import fp2int_pkg::*;
(
  input  logic [XLEN-1:0]         operand,
  input  logic                    src_dbl,
  output logic                    sign,
  output logic                    nan,
  output logic                    inf,
  output logic signed [EXP_W-1:0] uexp,
  output logic [MANT_W-1:0]       mant
);
  logic [DP_EW-1:0] dexp;
  logic [SP_EW-1:0] sexp;

  always_comb begin
    dexp = operand[XLEN-2 -: DP_EW];
    sexp = operand[30 -: SP_EW];
    if (src_dbl) begin
      sign = operand[XLEN-1];
      nan  = (&dexp) && (|operand[DP_FW-1:0]);
      inf  = (&dexp) && !(|operand[DP_FW-1:0]);
      uexp = (dexp == '0) ? EXP_W'(1 - DP_BIAS)
                          : $signed({{(EXP_W-DP_EW){1'b0}}, dexp}) - EXP_W'(DP_BIAS);
      mant = {(dexp != '0), operand[DP_FW-1:0]};
    end else begin
      sign = operand[31];
      nan  = (&sexp) && (|operand[SP_FW-1:0]);
      inf  = (&sexp) && !(|operand[SP_FW-1:0]);
      uexp = (sexp == '0) ? EXP_W'(1 - SP_BIAS)
                          : $signed({{(EXP_W-SP_EW){1'b0}}, sexp}) - EXP_W'(SP_BIAS);
      mant = {(sexp != '0), operand[SP_FW-1:0], {(DP_FW-SP_FW){1'b0}}};
    end
  end
endmodule

// File: rtl/fp2int_round.sv
module fp2int_round
  import fp2int_pkg::*;
(
  input  logic                    sign,
  input  logic signed [EXP_W-1:0] uexp,
  input  logic [MANT_W-1:0]       mant,
  input  logic [1:0]              rnd,
  output logic [XLEN:0]           mag,
  output logic                    big,
  output logic [XLEN-1:0]         modv
);
  logic [GRID_W-1:0]     grid;
  logic signed [EXP_W-1:0] sh_a;
  logic signed [EXP_W-1:0] sh_b;
  logic [XLEN-1:0]       ipart;
  logic                  guard;
  logic                  sticky;
  logic                  inc;

  always_comb begin
    sh_a   = uexp + EXP_W'(LOW_CUT);
    sh_b   = uexp - EXP_W'(DP_FW);
    big    = (uexp >= EXP_W'(XLEN));
    grid   = {{(GRID_W-MANT_W){1'b0}}, mant} << sh_a[6:0];
    ipart  = '0;
    guard  = 1'b0;
    sticky = 1'b0;
    if (uexp < -EXP_W'(LOW_CUT)) begin
      sticky = |mant;
    end else if (!big) begin
      ipart  = grid[GRID_W-1:FRAC_LSB];
      guard  = grid[FRAC_LSB-1];
      sticky = |grid[FRAC_LSB-2:0];
    end
    case (rnd)
      2'b00:   inc = guard && (sticky || ipart[0]);
      2'b10:   inc = !sign && (guard || sticky);
      2'b11:   inc = sign && (guard || sticky);
      default: inc = 1'b0;
    endcase
    mag  = {1'b0, ipart} + {{XLEN{1'b0}}, inc};
    modv = '0;
    if (big && (uexp < EXP_W'(DP_FW + XLEN)))
      modv = {{(XLEN-MANT_W){1'b0}}, mant} << sh_b[5:0];
  end
endmodule

// File: rtl/fp2int_policy.sv
module fp2int_policy
  import fp2int_pkg::*;
(
  input  s1_t             st,
  output logic [XLEN-1:0] res
);
  logic [XLEN-1:0] max_u, max_s, min_s, lo_val, hi_val, x, y;
  logic [XLEN:0]   lim_pos, lim_neg;

  always_comb begin
    max_u   = st.wide ? {XLEN{1'b1}} : {{(XLEN-NLEN){1'b0}}, {NLEN{1'b1}}};
    max_s   = st.wide ? {1'b0, {(XLEN-1){1'b1}}} : {{(XLEN-NLEN+1){1'b0}}, {(NLEN-1){1'b1}}};
    min_s   = ~max_s;
    lo_val  = st.sgn ? min_s : '0;
    hi_val  = st.sgn ? max_s : max_u;
    lim_pos = {1'b0, hi_val};
    lim_neg = {1'b0, max_s} + 1'b1;
    x       = st.big ? st.modv : st.mag[XLEN-1:0];
    y       = st.sign ? (~x + 1'b1) : x;
    res     = '0;
    case (st.pol)
      POL_WRAP: begin
        if (!(st.nan || st.inf)) begin
          if (st.wide)        res = y;
          else if (st.sgn)    res = {{(XLEN-NLEN){y[NLEN-1]}}, y[NLEN-1:0]};
          else                res = {{(XLEN-NLEN){1'b0}}, y[NLEN-1:0]};
        end
      end
      POL_CLAMP_MIN, POL_CLAMP_ZERO: begin
        if (st.nan)
          res = (st.pol == POL_CLAMP_MIN) ? lo_val : '0;
        else if (st.big || st.inf)
          res = st.sign ? lo_val : hi_val;
        else if (!st.sign)
          res = (st.mag > lim_pos) ? hi_val : st.mag[XLEN-1:0];
        else if (st.mag == '0 || !st.sgn)
          res = '0;
        else
          res = (st.mag > lim_neg) ? min_s : (~st.mag[XLEN-1:0] + 1'b1);
      end
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/fp2int_cvt.sv
module fp2int_cvt
  import fp2int_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [XLEN-1:0] operand,
  input  logic            src_dbl,
  input  logic            dst_wide,
  input  logic            dst_signed,
  input  logic [2:0]      mode,
  input  logic [1:0]      rnd_mode,
  output logic            out_valid,
  output logic [XLEN-1:0] result,
  output logic            illegal
);
  logic                    u_sign, u_nan, u_inf;
  logic signed [EXP_W-1:0] u_exp;
  logic [MANT_W-1:0]       u_mant;
  logic [1:0]              rnd_eff;
  logic [XLEN:0]           r_mag;
  logic                    r_big;
  logic [XLEN-1:0]         r_modv;
  s1_t                     s1_d, s1_q;
  logic                    v1_q, v2_q;
  logic [XLEN-1:0]         p_res, res_d, res_q;
  logic                    ill_d, ill_q;

  fp2int_unpack u_unp (
    .operand(operand), .src_dbl(src_dbl), .sign(u_sign), .nan(u_nan),
    .inf(u_inf), .uexp(u_exp), .mant(u_mant)
  );

  assign rnd_eff = mode[0] ? 2'b01 : rnd_mode;

  fp2int_round u_rnd (
    .sign(u_sign), .uexp(u_exp), .mant(u_mant), .rnd(rnd_eff),
    .mag(r_mag), .big(r_big), .modv(r_modv)
  );

  always_comb begin
    s1_d.sign = u_sign;
    s1_d.nan  = u_nan;
    s1_d.inf  = u_inf;
    s1_d.big  = r_big;
    s1_d.mag  = r_mag;
    s1_d.modv = r_modv;
    s1_d.wide = dst_wide;
    s1_d.sgn  = dst_signed;
    s1_d.pol  = pol_e'(mode[2:1]);
  end

  fp2int_policy u_pol (.st(s1_q), .res(p_res));

  always_comb begin
    ill_d = (s1_q.pol == POL_NONE);
    res_d = ill_d ? '0 : p_res;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      v1_q <= in_valid;
      v2_q <= v1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        s1_q <= '0;
    else if (in_valid) s1_q <= s1_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      ill_q <= 1'b0;
    end else if (v1_q) begin
      res_q <= res_d;
      ill_q <= ill_d;
    end
  end

  assign out_valid = v2_q;
  assign result    = res_q;
  assign illegal   = ill_q;
endmodule

// File: rtl/fp2int_cvt_chk.sv
module fp2int_cvt_chk
  import fp2int_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            dst_wide,
  input logic            dst_signed,
  input logic [2:0]      mode,
  input logic            out_valid,
  input logic [XLEN-1:0] result,
  input logic            illegal
);
  // R11
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);
  // R11
  idle_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 !out_valid);
  // R1
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && illegal) |-> (result == '0));
  // R1
  illegal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (illegal == ($past(mode[2:1], 2) == 2'b11)));
  // R10
  zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(dst_wide, 2) && !$past(dst_signed, 2))
      |-> (result[XLEN-1:NLEN] == '0));
  // R10
  sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(dst_wide, 2) && $past(dst_signed, 2))
      |-> (result[XLEN-1:NLEN] == {(XLEN-NLEN){result[NLEN-1]}}));
endmodule

bind fp2int_cvt fp2int_cvt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dst_wide(dst_wide),
  .dst_signed(dst_signed), .mode(mode), .out_valid(out_valid),
  .result(result), .illegal(illegal)
);

// File: tb/fp2int_cvt_test.sv
module fp2int_cvt_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] operand;
  logic        src_dbl, dst_wide, dst_signed;
  logic [2:0]  mode;
  logic [1:0]  rnd_mode;
  logic        out_valid;
  logic [63:0] result;
  logic        illegal;
  int nvec = 0;
  int nbad = 0;

  localparam logic [63:0] D_ONE  = 64'h3FF0000000000000;
  localparam logic [63:0] D_MONE = 64'hBFF0000000000000;
  localparam logic [63:0] D_1P5  = 64'h3FF8000000000000;
  localparam logic [63:0] D_2P5  = 64'h4004000000000000;
  localparam logic [63:0] D_M2P5 = 64'hC004000000000000;
  localparam logic [63:0] D_NAN  = 64'h7FF8000000000000;
  localparam logic [63:0] D_PINF = 64'h7FF0000000000000;
  localparam logic [63:0] D_NINF = 64'hFFF0000000000000;
  localparam logic [63:0] D_P31  = 64'h41E0000000000000;
  localparam logic [63:0] D_M31  = 64'hC1E0000000000000;
  localparam logic [63:0] D_P32  = 64'h41F0000000000000;
  localparam logic [63:0] D_P64  = 64'h43F0000000000000;

  always #4 clk = ~clk;

  fp2int_cvt uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
    .src_dbl(src_dbl), .dst_wide(dst_wide), .dst_signed(dst_signed),
    .mode(mode), .rnd_mode(rnd_mode), .out_valid(out_valid),
    .result(result), .illegal(illegal)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic conv(input string tag, input logic [63:0] op, input logic dbl,
                      input logic wide, input logic sgn, input logic [2:0] md,
                      input logic [1:0] rm, input logic [63:0] exp_res,
                      input logic exp_ill);
    @(negedge clk);
    in_valid = 1'b1; operand = op; src_dbl = dbl; dst_wide = wide;
    dst_signed = sgn; mode = md; rnd_mode = rm;
    @(negedge clk);
    in_valid = 1'b0; operand = ~op; mode = 3'b000; rnd_mode = ~rm;
    check({tag, " R11 early valid"}, {63'b0, out_valid}, 64'd0);
    @(negedge clk);
    check({tag, " R11 valid"}, {63'b0, out_valid}, 64'd1);
    check({tag, " illegal R1"}, {63'b0, illegal}, {63'b0, exp_ill});
    check(tag, result, exp_res);
  endtask

  task automatic t_reset;
    check("R11 reset valid", {63'b0, out_valid}, 64'd0);
    check("R1 reset illegal", {63'b0, illegal}, 64'd0);
  endtask

  task automatic t_illegal;
    conv("R1 mode110", D_2P5, 1, 1, 1, 3'b110, 2'b00, 64'd0, 1);
    conv("R1 mode111", D_NAN, 1, 0, 0, 3'b111, 2'b10, 64'd0, 1);
  endtask

  task automatic t_nan;
    conv("R2 nan i32", D_NAN, 1, 0, 1, 3'b000, 2'b00, 64'hFFFFFFFF80000000, 0);
    conv("R2 nan u64", D_NAN, 1, 1, 0, 3'b001, 2'b00, 64'd0, 0);
    conv("R2 nan i64", D_NAN, 1, 1, 1, 3'b001, 2'b00, 64'h8000000000000000, 0);
    conv("R3 nan i64", D_NAN, 1, 1, 1, 3'b010, 2'b00, 64'd0, 0);
    conv("R3 nan i32", D_NAN, 1, 0, 1, 3'b011, 2'b00, 64'd0, 0);
  endtask

  task automatic t_clamp;
    conv("R4 2^31 i32", D_P31, 1, 0, 1, 3'b000, 2'b00, 64'h000000007FFFFFFF, 0);
    conv("R4 -2^31 i32", D_M31, 1, 0, 1, 3'b000, 2'b00, 64'hFFFFFFFF80000000, 0);
    conv("R4 2^32 u32", D_P32, 1, 0, 0, 3'b010, 2'b00, 64'h00000000FFFFFFFF, 0);
    conv("R4 -1 u32", D_MONE, 1, 0, 0, 3'b000, 2'b00, 64'd0, 0);
    conv("R4 -inf i64", D_NINF, 1, 1, 1, 3'b010, 2'b00, 64'h8000000000000000, 0);
    conv("R4 +inf u64", D_PINF, 1, 1, 0, 3'b000, 2'b00, 64'hFFFFFFFFFFFFFFFF, 0);
    conv("R4 2^64 i64", D_P64, 1, 1, 1, 3'b011, 2'b00, 64'h7FFFFFFFFFFFFFFF, 0);
    conv("R4 2^31 i64", D_P31, 1, 1, 1, 3'b000, 2'b00, 64'h0000000080000000, 0);
  endtask

  task automatic t_round;
    conv("R5 2.5 rne", D_2P5, 1, 1, 1, 3'b000, 2'b00, 64'd2, 0);
    conv("R5 1.5 rne", D_1P5, 1, 1, 1, 3'b000, 2'b00, 64'd2, 0);
    conv("R5 2.5 rtz", D_2P5, 1, 1, 1, 3'b000, 2'b01, 64'd2, 0);
    conv("R5 2.5 rup", D_2P5, 1, 1, 1, 3'b010, 2'b10, 64'd3, 0);
    conv("R5 2.5 rdn", D_2P5, 1, 1, 1, 3'b000, 2'b11, 64'd2, 0);
    conv("R5 -2.5 rne", D_M2P5, 1, 1, 1, 3'b000, 2'b00, -64'sd2, 0);
    conv("R5 -2.5 rup", D_M2P5, 1, 1, 1, 3'b000, 2'b10, -64'sd2, 0);
    conv("R5 -2.5 rdn", D_M2P5, 1, 1, 1, 3'b010, 2'b11, -64'sd3, 0);
  endtask

  task automatic t_trunc;
    conv("R6 2.5 trunc rup", D_2P5, 1, 1, 1, 3'b001, 2'b10, 64'd2, 0);
    conv("R6 -2.5 trunc rdn", D_M2P5, 1, 1, 1, 3'b011, 2'b11, -64'sd2, 0);
    conv("R6 1.5 trunc rne", D_1P5, 1, 0, 0, 3'b101, 2'b00, 64'd1, 0);
  endtask

  task automatic t_wrap;
    conv("R7 nan wrap", D_NAN, 1, 1, 1, 3'b100, 2'b00, 64'd0, 0);
    conv("R7 +inf wrap", D_PINF, 1, 0, 0, 3'b101, 2'b00, 64'd0, 0);
    conv("R7 -inf wrap", D_NINF, 1, 1, 1, 3'b100, 2'b00, 64'd0, 0);
    conv("R8 2^32+5 i32", 64'h41F0000000500000, 1, 0, 1, 3'b100, 2'b00, 64'd5, 0);
    conv("R8 -1 u32", D_MONE, 1, 0, 0, 3'b100, 2'b00, 64'h00000000FFFFFFFF, 0);
    conv("R8 2^31 i32", D_P31, 1, 0, 1, 3'b101, 2'b00, 64'hFFFFFFFF80000000, 0);
    conv("R8 2^64+2^12", 64'h43F0000000000001, 1, 1, 1, 3'b100, 2'b00, 64'h1000, 0);
    conv("R8 2^84 u32", 64'h4530000000000000, 1, 0, 0, 3'b100, 2'b00, 64'd0, 0);
    conv("R8 -2.5 rdn u64", D_M2P5, 1, 1, 0, 3'b100, 2'b11, 64'hFFFFFFFFFFFFFFFD, 0);
  endtask

  task automatic t_single;
    conv("R9 sp 2.5 rup", 64'hDEADBEEF40200000, 0, 1, 1, 3'b000, 2'b10, 64'd3, 0);
    conv("R9 sp -1.5 trunc", 64'h12345678BFC00000, 0, 0, 1, 3'b001, 2'b00, 64'hFFFFFFFFFFFFFFFF, 0);
    conv("R9 sp nan", 64'h000000007FC00000, 0, 0, 1, 3'b000, 2'b00, 64'hFFFFFFFF80000000, 0);
    conv("R9 sp subnormal rup", 64'hFFFFFFFF00000001, 0, 0, 0, 3'b000, 2'b10, 64'd1, 0);
    conv("R9 sp subnormal rne", 64'h3FF0000000000001, 0, 1, 0, 3'b000, 2'b00, 64'd0, 0);
  endtask

  task automatic t_ext;
    conv("R10 sext i32", D_MONE, 1, 0, 1, 3'b000, 2'b00, 64'hFFFFFFFFFFFFFFFF, 0);
    conv("R10 zext u32", 64'h41EFFFFFFFE00000, 1, 0, 0, 3'b000, 2'b00, 64'h00000000FFFFFFFF, 0);
  endtask

  task automatic t_b2b;
    @(negedge clk);
    in_valid = 1'b1; operand = D_ONE; src_dbl = 1; dst_wide = 1; dst_signed = 1;
    mode = 3'b000; rnd_mode = 2'b00;
    @(negedge clk);
    operand = D_M2P5; mode = 3'b110;
    @(negedge clk);
    in_valid = 1'b0;
    check("R11 b2b first", result, 64'd1);
    check("R11 b2b first ill", {63'b0, illegal}, 64'd0);
    @(negedge clk);
    check("R11 b2b second", result, 64'd0);
    check("R11 b2b second ill", {63'b0, illegal}, 64'd1);
    @(negedge clk);
    check("R11 b2b drain", {63'b0, out_valid}, 64'd0);
  endtask

  initial begin
    #(8 * 200000);
    nbad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; operand = '0; src_dbl = 1'b1;
    dst_wide = 1'b1; dst_signed = 1'b1; mode = 3'b000; rnd_mode = 2'b00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_illegal();
    t_nan();
    t_clamp();
    t_round();
    t_trunc();
    t_wrap();
    t_single();
    t_ext();
    t_b2b();
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule